// File: doc/BRIEF.md
# Two-Wire Register Slave with 16-Bit Words

This block is a slave on a two-wire serial bus (one clock line, one open-drain data line). It lets a bus master read and write a bank of 16-bit registers that are selected by an 8-bit register pointer. Both bus lines are brought into a faster system clock through synchronizers and edge detectors. All protocol decisions are taken on the detected edges.

A write transaction has four parts: a start, the device address with direction bit 0, the register pointer byte, and then pairs of data bytes. Each pair forms one register word, and the high byte comes first. A read first loads the pointer with a write-mode header. A repeated start and the device address with direction bit 1 follow. The slave then sends words high byte first, and every byte goes out most significant bit first. The pointer moves on by one only after a complete word, in both directions. A small register file inside the block holds the words, so the slave can be used and tested on its own.

Top module: `tws_slave`

## Requirements
- R1: After reset the data-line pull-down output `sda_oe` is 0 and the slave is idle. Register i holds the value {8'hA5, i}.
- R2: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. After a stop, bytes clocked without a new start get no acknowledge.
- R3: After a start, the first byte is a 7-bit device address in bits 7..1 followed by a direction bit in bit 0 (0 = write, 1 = read). The slave acknowledges the byte by driving the data line low in the ninth clock slot when bits 7..1 equal the parameter DEV_ADDR.
- R4: A device address that does not match gets no acknowledge, and every later byte gets none either, until the next start.
- R5: In a write, the byte after the device address loads the register pointer, and the slave acknowledges it.
- R6: In a write, each data byte is acknowledged. The first byte of a pair is the high byte and the second is the low byte. The register is written when the low byte arrives.
- R7: The pointer increments by one after each complete 16-bit word, in write and in read bursts. The register index is the pointer modulo NUM_REGS, which must be a power of two.
- R8: After a repeated start with the read direction, the slave sends the word at the pointer, high byte first and MSB first. Each byte is followed by a master acknowledge slot.
- R9: A no-acknowledge from the master (data line high in that slot) ends the read. The slave releases the data line and drives nothing until the next start.
- R10: A stop or a start that comes after only the high byte of a word leaves that register unchanged.
- R11: The slave changes `sda_oe` only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Two functions can meet on the same clock edge of the serial bus. The first is the slot in which the slave ends a byte (its acknowledge, or the master's acknowledge in a read). The second is a start or stop that the master issues right after that slot, while a word is only half written or a read has just ended. The bench provokes both cases on purpose. It stops after a lone high byte, sends a repeated start after a high byte, and clocks bytes after a master no-acknowledge. It judges them by reading the registers back through the bus and comparing with a bench model. It also watches that the data line stays released and that the pull-down never moves while the clock line is high.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_WR,
        ST_RD,
        ST_SKIP
    } tws_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } tws_bus_t;

    function automatic logic [WORD_W-1:0] tws_reset_word(input int idx);
        logic [7:0] lo;
        lo = idx[7:0];
        return {8'hA5, lo};
    endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output tws_bus_t bus
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain[s] <= 1'b1;
                    sda_chain[s] <= 1'b1;
                end else if (s == 0) begin
                    scl_chain[s] <= scl_in;
                    sda_chain[s] <= sda_in;
                end else begin
                    scl_chain[s] <= scl_chain[(s == 0) ? 0 : s-1];
                    sda_chain[s] <= sda_chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[LAST];
            sda_prev <= sda_chain[LAST];
        end
    end

    always_comb begin
        bus.scl   = scl_chain[LAST];
        bus.sda   = sda_chain[LAST];
        bus.start = scl_chain[LAST] && scl_prev && sda_prev && !sda_chain[LAST];
        bus.stop  = scl_chain[LAST] && scl_prev && !sda_prev && sda_chain[LAST];
        bus.rise  = scl_chain[LAST] && !scl_prev;
        bus.fall  = !scl_chain[LAST] && scl_prev;
    end

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
    import tws_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [7:0]        raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [WORD_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= tws_reset_word(i);
            end
        end else if (we) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
        end
    end

    assign rdata = mem[raddr[IDX_W-1:0]];

endmodule

// File: rtl/tws_proto.sv
module tws_proto
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  tws_bus_t          bus,
    input  logic [WORD_W-1:0] rd_word,
    output logic [7:0]        rptr,
    output logic              we,
    output logic [7:0]        waddr,
    output logic [WORD_W-1:0] wdata,
    output logic              sda_oe
);
    tws_state_e        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [BYTE_W-1:0] hold;
    logic [7:0]        ptr;
    logic              ack_slot;
    logic              rw;
    logic              byte_sel;
    logic              rx_state;
    logic [BYTE_W-1:0] next_tx;

    assign rx_state = (state == ST_DEV) || (state == ST_REG) || (state == ST_WR);
    assign next_tx  = byte_sel ? rd_word[7:0] : rd_word[15:8];
    assign rptr     = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txsh     <= '0;
            hold     <= '0;
            ptr      <= '0;
            ack_slot <= 1'b0;
            rw       <= 1'b0;
            byte_sel <= 1'b0;
            sda_oe   <= 1'b0;
            we       <= 1'b0;
            waddr    <= '0;
            wdata    <= '0;
        end else begin
            we <= 1'b0;
            if (bus.start) begin
                state    <= ST_DEV;
                cnt      <= '0;
                ack_slot <= 1'b0;
                byte_sel <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (bus.stop) begin
                state    <= ST_IDLE;
                cnt      <= '0;
                ack_slot <= 1'b0;
                byte_sel <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (bus.rise) begin
                if (rx_state && !ack_slot && cnt < 4'd8) begin
                    shreg <= {shreg[6:0], bus.sda};
                    cnt   <= cnt + 4'd1;
                end else if (state == ST_RD && ack_slot) begin
                    if (bus.sda) begin
                        state    <= ST_SKIP;
                        ack_slot <= 1'b0;
                    end else begin
                        if (byte_sel) ptr <= ptr + 8'd1;
                        byte_sel <= ~byte_sel;
                    end
                end
            end else if (bus.fall) begin
                if (rx_state && !ack_slot && cnt == 4'd8) begin
                    cnt <= '0;
                    case (state)
                        ST_DEV: begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rw       <= shreg[0];
                                ack_slot <= 1'b1;
                                sda_oe   <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        ST_REG: begin
                            ptr      <= shreg;
                            byte_sel <= 1'b0;
                            ack_slot <= 1'b1;
                            sda_oe   <= 1'b1;
                        end
                        default: begin
                            if (!byte_sel) begin
                                hold     <= shreg;
                                byte_sel <= 1'b1;
                            end else begin
                                we       <= 1'b1;
                                waddr    <= ptr;
                                wdata    <= {hold, shreg};
                                ptr      <= ptr + 8'd1;
                                byte_sel <= 1'b0;
                            end
                            ack_slot <= 1'b1;
                            sda_oe   <= 1'b1;
                        end
                    endcase
                end else if (rx_state && ack_slot) begin
                    ack_slot <= 1'b0;
                    sda_oe   <= 1'b0;
                    if (state == ST_DEV) begin
                        if (rw) begin
                            state  <= ST_RD;
                            txsh   <= next_tx;
                            sda_oe <= ~next_tx[7];
                            cnt    <= 4'd1;
                        end else begin
                            state <= ST_REG;
                        end
                    end else if (state == ST_REG) begin
                        state <= ST_WR;
                    end
                end else if (state == ST_RD) begin
                    if (ack_slot) begin
                        ack_slot <= 1'b0;
                        txsh     <= next_tx;
                        sda_oe   <= ~next_tx[7];
                        cnt      <= 4'd1;
                    end else if (cnt == 4'd8) begin
                        sda_oe   <= 1'b0;
                        ack_slot <= 1'b1;
                        cnt      <= '0;
                    end else begin
                        sda_oe <= ~txsh[6];
                        txsh   <= {txsh[6:0], 1'b0};
                        cnt    <= cnt + 4'd1;
                    end
                end
            end
        end
    end

    // R1: an idle slave never pulls the line
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R2: a start always puts the slave back to address decode, line released
    a_r2_start_to_dev: assert property (@(posedge clk) disable iff (rst)
        bus.start |=> (state == ST_DEV && !sda_oe));

    // R2: a stop always returns to idle
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        bus.stop |=> (state == ST_IDLE));

    // R4/R9: a slave that dropped out of the transaction stays off the line
    a_r4_skip_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_oe);

    // R7: a word write moves the pointer one past the written register
    a_r7_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        we |-> (ptr == waddr + 8'd1));

    // R11: the pull-down only moves while the synchronized clock was low
    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(bus.scl));

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    tws_bus_t          bus;
    logic [WORD_W-1:0] rd_word;
    logic [7:0]        rptr;
    logic              we;
    logic [7:0]        waddr;
    logic [WORD_W-1:0] wdata;

    tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .bus    (bus)
    );

    tws_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .rd_word (rd_word),
        .rptr    (rptr),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .sda_oe  (sda_oe)
    );

    tws_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (rptr),
        .rdata (rd_word)
    );

endmodule

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
    localparam logic [6:0] DEV = 7'h48;
    localparam int NUM = 16;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    int checks = 0;
    int fails = 0;
    int viol = 0;
    logic oe_q = 1'b0;
    logic [15:0] model [NUM];
    logic [15:0] wbuf [4];
    logic [15:0] rbuf [4];
    logic done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    tws_slave #(.DEV_ADDR(DEV), .NUM_REGS(NUM)) dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    function automatic logic [15:0] rv(input int i);
        return {8'hA5, 8'(i)};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic v);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        v = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic do_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic sbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(ack);
    endtask

    task automatic gbyte(output logic [7:0] b, input logic mack);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            rbit(v);
            b[i] = v;
        end
        wbit(mack ? 1'b0 : 1'b1);
    endtask

    // write n words starting at register reg_a; acks checked under tag
    task automatic bus_write(input logic [7:0] reg_a, input int n, input string tag);
        logic a;
        do_start();
        sbyte({DEV, 1'b0}, a); chk(a == 1'b0, {tag, " R3 dev ack"}, a, 0);
        sbyte(reg_a, a);       chk(a == 1'b0, {tag, " R5 reg ack"}, a, 0);
        for (int w = 0; w < n; w++) begin
            sbyte(wbuf[w][15:8], a); chk(a == 1'b0, {tag, " R6 hi ack"}, a, 0);
            sbyte(wbuf[w][7:0], a);  chk(a == 1'b0, {tag, " R6 lo ack"}, a, 0);
            model[(int'(reg_a) + w) % NUM] = wbuf[w];
        end
        do_stop();
    endtask

    task automatic bus_read(input logic [7:0] reg_a, input int n);
        logic a;
        logic [7:0] h, l;
        do_start();
        sbyte({DEV, 1'b0}, a);
        sbyte(reg_a, a);
        do_start();
        sbyte({DEV, 1'b1}, a); chk(a == 1'b0, "R8 read dev ack", a, 0);
        for (int w = 0; w < n; w++) begin
            gbyte(h, 1'b1);
            gbyte(l, (w != n-1));
            rbuf[w] = {h, l};
        end
        do_stop();
    endtask

    task automatic check_read(input logic [7:0] reg_a, input int n, input string tag);
        bus_read(reg_a, n);
        for (int w = 0; w < n; w++)
            chk(rbuf[w] == model[(int'(reg_a) + w) % NUM], tag, rbuf[w], model[(int'(reg_a) + w) % NUM]);
    endtask

    always @(negedge clk) begin
        if (!rst && (sda_oe !== oe_q) && m_scl) viol++;
        oe_q = sda_oe;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a, v;
        logic [7:0] b;
        int seed;
        seed = $urandom(32'h5eed);
        for (int i = 0; i < NUM; i++) model[i] = rv(i);
        tick(4);
        rst = 1'b0;
        tick(4);
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);

        // R1 reset contents
        check_read(8'd2, 3, "R1 reset words");

        // R6/R7 write burst then read back
        wbuf[0] = 16'h1234; wbuf[1] = 16'hBEEF; wbuf[2] = 16'h00FF;
        bus_write(8'd5, 3, "burst");
        check_read(8'd5, 3, "R6 R7 R8 burst readback");

        // R7 wrap of pointer modulo NUM
        wbuf[0] = 16'hCAFE; wbuf[1] = 16'h7001;
        bus_write(8'(NUM-1), 2, "wrap");
        check_read(8'(NUM-1), 2, "R7 wrap readback");

        // R4 mismatching address: no ack for address and following bytes
        do_start();
        sbyte({DEV ^ 7'h01, 1'b0}, a); chk(a == 1'b1, "R4 bad addr nack", a, 1);
        sbyte(8'h03, a);               chk(a == 1'b1, "R4 later byte nack", a, 1);
        sbyte(8'h55, a);               chk(a == 1'b1, "R4 data byte nack", a, 1);
        do_stop();
        check_read(8'd3, 1, "R4 register untouched");

        // R2 after stop, bytes without start are ignored
        sbyte({DEV, 1'b0}, a); chk(a == 1'b1, "R2 no ack without start", a, 1);
        do_stop();

        // R10 stop after lone high byte
        do_start();
        sbyte({DEV, 1'b0}, a); sbyte(8'd3, a); sbyte(8'h99, a);
        do_stop();
        check_read(8'd3, 1, "R10 stop half word");

        // R10 repeated start after full word plus high byte
        do_start();
        sbyte({DEV, 1'b0}, a); sbyte(8'd4, a);
        sbyte(8'h4A, a); sbyte(8'h4B, a); sbyte(8'h77, a);
        model[4] = 16'h4A4B;
        do_start();
        sbyte({DEV, 1'b1}, a);
        gbyte(b, 1'b1); rbuf[0][15:8] = b;
        gbyte(b, 1'b0); rbuf[0][7:0] = b;
        do_stop();
        chk(rbuf[0] == model[5], "R10 restart half word reg5", rbuf[0], model[5]);
        check_read(8'd4, 1, "R6 R10 reg4 written");

        // R9 master nack ends read; line stays released
        do_start();
        sbyte({DEV, 1'b0}, a); sbyte(8'd0, a);
        do_start();
        sbyte({DEV, 1'b1}, a);
        gbyte(b, 1'b0);
        tick(2*Q);
        chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        b = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            rbit(v);
            b[i] = v;
        end
        rbit(v);
        chk(b == 8'hFF && v, "R9 no drive after nack", {b, v}, 9'h1FF);
        do_stop();

        // random mix
        for (int it = 0; it < 12; it++) begin
            logic [7:0] ra;
            int n;
            ra = 8'($urandom);
            n = 1 + ($urandom % 3);
            for (int w = 0; w < n; w++) wbuf[w] = 16'($urandom);
            bus_write(ra, n, "rand");
            check_read(ra, n, "R6 R7 R8 random readback");
        end

        chk(viol == 0, "R11 oe change with scl high", viol, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule